// File: doc/BRIEF.md
# Background memory CRC scrub checker

The block walks a configuration-style memory in the background, one 32-bit word per clock. It reads each word through a simple read port and folds every word that counts into a running CRC-32. When a full pass over the address space is complete, the result is checked against a stored golden signature. A mismatch raises a sticky error flag, so corruption of static content, for example a flipped bit, stays visible until software parks the interface again.

Three conditions gate the scan. The configuration-done input must be high. The interface must have been parked by a desync pulse. The debug port must not own the internal bus. Two regions of the address map are treated specially. Dynamic content, such as LUT-based RAM, shift registers and port-accessible registers, is still read but left out of the CRC. The block-memory region is never read at all, so user traffic to it is not disturbed.

A writer that wants to reconfigure raises a request. The scan stops issuing reads, lets the read already in flight drain, and then grants the bus. When the writer releases the request, the scan restarts from address zero. After partial reconfiguration a recalculation request makes the next complete pass become the new golden value. That pass is not compared.

Top module: `cfg_scrub_top`

## Requirements
- R1: No read is issued (`mem_rd_en` stays 0), no pass completes and no golden value is captured unless `cfg_done` is high and a `desync_cmd` pulse has been seen since reset. Either condition alone is not enough.
- R2: A one-cycle `desync_cmd` pulse parks the interface, and parking is sticky until reset. The same pulse forces `crc_error` to 0 in the following cycle.
- R3: The debug port owns the bus while `dbg_own` is high. In that time `mem_rd_en` is 0, the running CRC does not change and `pass_count` does not advance. When ownership ends, the scan continues from where it stopped, and a pass over unchanged memory still matches.
- R4: Words at addresses `MASK_LO`..`MASK_HI` are read but excluded from the CRC. Changing them never causes a mismatch.
- R5: Words at addresses `SKIP_LO`..`SKIP_HI` are never read. `mem_rd_en` is never high with `mem_addr` in that range, and changing these words never causes a mismatch.
- R6: The CRC of a pass starts at 0xFFFFFFFF. For each counted word in ascending address order, it shifts in the 32 data bits MSB first with polynomial 0x04C11DB7, with no reflection and no final inversion. At the end of a compared pass `pass_count` increments by one. If the CRC differs from `golden_sig`, `crc_error` is set, and it then stays set through later passes until a desync pulse.
- R7: The first complete pass after reset is captured into `golden_sig`. So is the first complete pass that starts after a `recalc_req` pulse. A captured pass neither changes `pass_count` nor touches `crc_error`.
- R8: While `reconf_req` is high the scan issues no new reads. `reconf_grant` rises within `DRAIN_MAX` (130) cycles and stays high with `mem_rd_en` at 0 until `reconf_req` falls. This also holds while `dbg_own` is high, in which case the in-flight word is dropped.
- R9: After `reconf_req` falls, `reconf_grant` falls. The first read that follows is at address 0, and it begins a fresh pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration-done level |
| desync_cmd | input | 1 | One-cycle desync pulse; parks the interface and clears the error |
| dbg_own | input | 1 | Debug port owns the internal bus |
| reconf_req | input | 1 | Reconfiguration request level from a writer |
| recalc_req | input | 1 | One-cycle pulse: capture the next full pass as golden |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_addr | output | $clog2(DEPTH) | Read address |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe, held while no read |
| reconf_grant | output | 1 | Bus granted to the writer |
| crc_error | output | 1 | Sticky signature mismatch flag |
| pass_count | output | PCNT_W | Number of compared passes |
| golden_sig | output | 32 | Stored golden signature |

## Verification
The assertions assume that `desync_cmd` and `recalc_req` are single-cycle pulses. They also assume that the memory returns data one cycle after a strobe and holds it while no read is issued, because a word left in flight under debug ownership is folded late. The bench drives the memory in exactly that way, changes memory content only between reads or while the bus is granted, and keeps desync pulses away from pass ends that could mismatch. Debug ownership is toggled at random from a fixed seed during scanning, and directed cases cover gating order, masked and skipped regions, corruption, recalculation and both drain paths.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;

    localparam int          WORD_W    = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_GRANT
    } scan_state_t;

    typedef enum logic [1:0] {
        WK_PLAIN,
        WK_MASK,
        WK_SKIP
    } word_kind_t;

    typedef struct packed {
        logic valid;
        logic masked;
    } rd_tag_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                               input logic [31:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic word_kind_t classify(input int a, input int mlo, input int mhi,
                                            input int slo, input int shi);
        if (a >= slo && a <= shi) return WK_SKIP;
        if (a >= mlo && a <= mhi) return WK_MASK;
        return WK_PLAIN;
    endfunction

endpackage

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
    import cfg_scrub_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int MASK_LO   = 8,
    parameter int MASK_HI   = 15,
    parameter int SKIP_LO   = 40,
    parameter int SKIP_HI   = 47,
    parameter int DRAIN_MAX = 130,
    localparam int AW  = $clog2(DEPTH + 1),
    localparam int MAW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_done,
    input  logic           desync_cmd,
    input  logic           dbg_own,
    input  logic           reconf_req,
    output logic           mem_rd_en,
    output logic [MAW-1:0] mem_addr,
    output logic           fold,
    output logic           pass_end,
    output logic           restart,
    output logic           reconf_grant
);

    localparam int DCW = $clog2(DRAIN_MAX + 1);

    scan_state_t   st_q, st_d;
    logic          parked_q;
    logic [AW-1:0] addr_q;
    rd_tag_t       tag_q;
    word_kind_t    kind;
    logic          run, scan_ok, at_end, issue;
    logic [DCW-1:0] drain_cnt_q;

    assign run     = cfg_done && parked_q;
    assign kind    = classify(int'(addr_q), MASK_LO, MASK_HI, SKIP_LO, SKIP_HI);
    assign scan_ok = (st_q == ST_SCAN) && run && !reconf_req && !dbg_own;
    assign at_end  = (addr_q == AW'(DEPTH));
    assign issue   = scan_ok && !at_end && (kind != WK_SKIP);

    assign mem_rd_en    = issue;
    assign mem_addr     = addr_q[MAW-1:0];
    assign pass_end     = scan_ok && at_end && !tag_q.valid;
    assign fold         = tag_q.valid && !tag_q.masked && !dbg_own;
    assign restart      = (st_q != ST_SCAN);
    assign reconf_grant = (st_q == ST_GRANT);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (reconf_req) st_d = ST_DRAIN;
                      else if (run)   st_d = ST_SCAN;
            ST_SCAN:  if (reconf_req) st_d = ST_DRAIN;
                      else if (!run)  st_d = ST_IDLE;
            ST_DRAIN: if (!tag_q.valid || dbg_own) st_d = ST_GRANT;
            ST_GRANT: if (!reconf_req) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            parked_q    <= 1'b0;
            addr_q      <= '0;
            tag_q       <= '0;
            drain_cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (desync_cmd) parked_q <= 1'b1;
            if (st_q != ST_SCAN || pass_end)  addr_q <= '0;
            else if (scan_ok && !at_end)      addr_q <= addr_q + 1'b1;
            if (!dbg_own) begin
                tag_q.valid  <= issue;
                tag_q.masked <= (kind == WK_MASK);
            end
            if (st_q == ST_DRAIN) drain_cnt_q <= drain_cnt_q + 1'b1;
            else                  drain_cnt_q <= '0;
        end
    end

    // R1: nothing is read until done and parked both hold
    assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_done || !parked_q) |-> !mem_rd_en);

    // R5: block-memory region is never addressed by a read
    assert_skip_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !(int'(mem_addr) >= SKIP_LO && int'(mem_addr) <= SKIP_HI));

    // R8: drain is bounded and the granted bus sees no reads
    assert_drain_bound_R8: assert property (@(posedge clk) disable iff (rst)
        drain_cnt_q < DCW'(DRAIN_MAX));
    assert_grant_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        reconf_grant |-> !mem_rd_en);
    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (reconf_grant && reconf_req) |=> reconf_grant);

    // R9: release returns the scan to address zero
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(reconf_grant) |-> (mem_addr == '0));

endmodule

// File: rtl/cfg_scrub_sig.sv
module cfg_scrub_sig
    import cfg_scrub_pkg::*;
#(
    parameter int PCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rdata,
    input  logic              fold,
    input  logic              pass_end,
    input  logic              restart,
    input  logic              desync_cmd,
    input  logic              recalc_req,
    input  logic              dbg_own,
    output logic [WORD_W-1:0] golden_sig,
    output logic              crc_error,
    output logic [PCNT_W-1:0] pass_count
);

    logic [WORD_W-1:0] crc_q;
    logic              cap_cur_q, cap_arm_q;
    logic              mismatch, compared;

    assign compared = pass_end && !cap_cur_q;
    assign mismatch = compared && (crc_q != golden_sig);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q      <= CRC_SEED;
            golden_sig <= '0;
            crc_error  <= 1'b0;
            pass_count <= '0;
            cap_cur_q  <= 1'b1;
            cap_arm_q  <= 1'b0;
        end else begin
            if (restart || pass_end) crc_q <= CRC_SEED;
            else if (fold)           crc_q <= crc32_step(crc_q, rdata);

            if (restart) begin
                cap_cur_q <= cap_cur_q | cap_arm_q | recalc_req;
                cap_arm_q <= 1'b0;
            end else if (pass_end) begin
                cap_cur_q <= cap_arm_q;
                cap_arm_q <= recalc_req;
            end else begin
                cap_arm_q <= cap_arm_q | recalc_req;
            end

            if (pass_end && cap_cur_q) golden_sig <= crc_q;
            if (compared)              pass_count <= pass_count + 1'b1;
            crc_error <= desync_cmd ? 1'b0 : (crc_error | mismatch);
        end
    end

    // R2: desync clears the flag
    assert_desync_clear_R2: assert property (@(posedge clk) disable iff (rst)
        desync_cmd |=> !crc_error);

    // R3: debug ownership freezes the running CRC
    assert_dbg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg_own && !restart) |=> $stable(crc_q));

    // R6: error stays set until desync
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (crc_error && !desync_cmd) |=> crc_error);

    // R7: a capture pass leaves the count and flag alone
    assert_capture_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (pass_end && cap_cur_q && !desync_cmd) |=> ($stable(pass_count) && $stable(crc_error)));

endmodule

// File: rtl/cfg_scrub_top.sv
module cfg_scrub_top
    import cfg_scrub_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int MASK_LO   = 8,
    parameter int MASK_HI   = 15,
    parameter int SKIP_LO   = 40,
    parameter int SKIP_HI   = 47,
    parameter int DRAIN_MAX = 130,
    parameter int PCNT_W    = 16,
    localparam int MAW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done,
    input  logic              desync_cmd,
    input  logic              dbg_own,
    input  logic              reconf_req,
    input  logic              recalc_req,
    output logic              mem_rd_en,
    output logic [MAW-1:0]    mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reconf_grant,
    output logic              crc_error,
    output logic [PCNT_W-1:0] pass_count,
    output logic [WORD_W-1:0] golden_sig
);

    logic fold, pass_end, restart;

    cfg_scrub_ctrl #(
        .DEPTH(DEPTH), .MASK_LO(MASK_LO), .MASK_HI(MASK_HI),
        .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI), .DRAIN_MAX(DRAIN_MAX)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .desync_cmd(desync_cmd),
        .dbg_own(dbg_own), .reconf_req(reconf_req),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .fold(fold), .pass_end(pass_end), .restart(restart),
        .reconf_grant(reconf_grant)
    );

    cfg_scrub_sig #(.PCNT_W(PCNT_W)) u_sig (
        .clk(clk), .rst(rst), .rdata(mem_rdata), .fold(fold),
        .pass_end(pass_end), .restart(restart), .desync_cmd(desync_cmd),
        .recalc_req(recalc_req), .dbg_own(dbg_own),
        .golden_sig(golden_sig), .crc_error(crc_error), .pass_count(pass_count)
    );

endmodule

// File: tb/cfg_scrub_top_tb.sv
`timescale 1ns/1ps
module cfg_scrub_top_tb;

    localparam int DEPTH = 64, MLO = 8, MHI = 15, SLO = 40, SHI = 47, DMAX = 130;
    localparam int MAW = $clog2(DEPTH);

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_done = 0, desync_cmd = 0, dbg_own = 0, reconf_req = 0, recalc_req = 0;
    logic mem_rd_en, reconf_grant, crc_error;
    logic [MAW-1:0] mem_addr;
    logic [31:0] mem_rdata = '0, golden_sig;
    logic [15:0] pass_count;
    logic [31:0] mem [DEPTH];

    int checks = 0, errors = 0, cycles = 0, skip_hits = 0, reads = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    cfg_scrub_top u_dut (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .desync_cmd(desync_cmd),
        .dbg_own(dbg_own), .reconf_req(reconf_req), .recalc_req(recalc_req),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .reconf_grant(reconf_grant), .crc_error(crc_error),
        .pass_count(pass_count), .golden_sig(golden_sig)
    );

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    always begin
        @(negedge clk); #2;
        cycles++;
        if (mem_rd_en) reads++;
        if (mem_rd_en && int'(mem_addr) >= SLO && int'(mem_addr) <= SHI) skip_hits++;
        if (cycles > 150000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    function automatic logic [31:0] model_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int a = 0; a < DEPTH; a++) begin
            if ((a >= MLO && a <= MHI) || (a >= SLO && a <= SHI)) continue;
            for (int b = 31; b >= 0; b--) begin
                logic f = c[31] ^ mem[a][b];
                c = c << 1;
                if (f) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    task automatic finish_up();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_desync();
        desync_cmd = 1; @(negedge clk); desync_cmd = 0;
    endtask

    task automatic wait_count(input int target);
        for (int i = 0; i < 2000; i++) begin
            if (int'(pass_count) == target) break;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        int r0, p0, lat, viol, addr_first;
        logic [31:0] g_old;
        void'($urandom(32'hC0FFEE));
        for (int a = 0; a < DEPTH; a++) mem[a] = $urandom;
        tick(4); rst = 0; #1;
        check(!crc_error && pass_count == 0 && !reconf_grant && !mem_rd_en,
              "R1 reset state", {crc_error, reconf_grant, mem_rd_en}, 0);

        cfg_done = 1; r0 = reads; tick(40);
        check(reads == r0, "R1 done without desync", reads - r0, 0);
        cfg_done = 0; pulse_desync(); r0 = reads; tick(40);
        check(reads == r0 && pass_count == 0 && golden_sig == 0,
              "R1 desync without done", reads - r0, 0);

        cfg_done = 1;
        for (int i = 0; i < 500 && golden_sig != model_crc(); i++) @(negedge clk);
        #1;
        check(golden_sig == model_crc(), "R7 first pass golden", golden_sig, model_crc());
        check(pass_count == 0, "R7 capture not counted", pass_count, 0);
        wait_count(1);
        check(pass_count == 1 && !crc_error, "R6 clean compare", {pass_count, crc_error}, 32'h2);

        viol = 0; p0 = pass_count;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); dbg_own = (($urandom % 4) == 0); #1;
            if (dbg_own && mem_rd_en) viol++;
        end
        @(negedge clk); dbg_own = 0;
        check(viol == 0, "R3 no reads under debug", viol, 0);
        wait_count(int'(pass_count) + 2); #1;
        check(!crc_error && int'(pass_count) > p0, "R3 passes match after debug stalls", crc_error, 0);

        @(negedge clk); dbg_own = 1; p0 = pass_count; tick(150); #1;
        check(int'(pass_count) == p0, "R3 count frozen under debug", pass_count, p0);
        @(negedge clk); dbg_own = 0;
        wait_count(p0 + 2); #1;
        check(!crc_error, "R3 resume match", crc_error, 0);

        mem[MLO + 3] = mem[MLO + 3] ^ 32'hFFFF_0000;
        wait_count(int'(pass_count) + 2); #1;
        check(!crc_error, "R4 masked change ignored", crc_error, 0);
        mem[SLO + 1] = ~mem[SLO + 1];
        wait_count(int'(pass_count) + 2); #1;
        check(!crc_error, "R5 skipped change ignored", crc_error, 0);
        check(skip_hits == 0, "R5 no reads in skip region", skip_hits, 0);

        g_old = golden_sig;
        mem[20] = mem[20] ^ 32'h0000_0100;
        wait_count(int'(pass_count) + 2); #1;
        check(crc_error, "R6 corruption detected", crc_error, 1);
        check(golden_sig == g_old, "R6 golden kept on compare", golden_sig, g_old);
        mem[20] = mem[20] ^ 32'h0000_0100;
        wait_count(int'(pass_count) + 2); #1;
        check(crc_error, "R6 flag sticky over clean passes", crc_error, 1);
        wait_count(int'(pass_count) + 1);
        tick(3); pulse_desync(); #1;
        check(!crc_error, "R2 desync clears flag", crc_error, 0);
        wait_count(int'(pass_count) + 1); #1;
        check(!crc_error, "R2 clean after clear", crc_error, 0);

        tick(17); reconf_req = 1; lat = 0;
        while (!reconf_grant && lat < 200) begin @(negedge clk); #1; lat++; end
        check(reconf_grant && lat <= DMAX, "R8 grant within drain bound", lat, DMAX);
        viol = 0; p0 = pass_count;
        mem[20] = mem[20] ^ 32'h00F0_000F; mem[30] = ~mem[30];
        recalc_req = 1; @(negedge clk); recalc_req = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (mem_rd_en || !reconf_grant) viol++;
        end
        check(viol == 0, "R8 grant held, bus quiet", viol, 0);
        reconf_req = 0; @(negedge clk); #1;
        check(!reconf_grant, "R9 grant released", reconf_grant, 0);
        addr_first = -1;
        for (int i = 0; i < 20 && addr_first < 0; i++) begin
            if (mem_rd_en) addr_first = int'(mem_addr);
            else begin @(negedge clk); #1; end
        end
        check(addr_first == 0, "R9 restart at address zero", addr_first, 0);
        for (int i = 0; i < 500 && golden_sig != model_crc(); i++) @(negedge clk);
        #1;
        check(golden_sig == model_crc(), "R7 recalculated golden", golden_sig, model_crc());
        check(int'(pass_count) == p0 && !crc_error, "R7 recalc pass not compared", pass_count, p0);
        wait_count(p0 + 1); #1;
        check(!crc_error && int'(pass_count) == p0 + 1, "R7 new golden matches", crc_error, 0);

        tick(9); dbg_own = 1; reconf_req = 1; lat = 0;
        while (!reconf_grant && lat < 200) begin @(negedge clk); #1; lat++; end
        check(reconf_grant && lat <= 2, "R8 debug-path drain", lat, 2);
        @(negedge clk); reconf_req = 0; dbg_own = 0;
        p0 = pass_count;
        wait_count(p0 + 2); #1;
        check(!crc_error && int'(pass_count) == p0 + 2, "R9 fresh passes after debug drain",
              pass_count, p0 + 2);
        check(skip_hits == 0, "R5 skip region untouched overall", skip_hits, 0);

        finish_up();
    end

endmodule